// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is the bus-facing front end of a quad digital potentiometer. It watches the two lines of a two-wire serial bus (clock and data) with a fast system clock, finds start and stop conditions, and accepts an 8-bit device address made of a fixed 4-bit type code and four strap pins. After a matching address it takes an instruction byte, which names an operation, a register slot and one of four potentiometers. Depending on the operation it then either receives one data byte, sends one data byte taken from the register back end, or ends. Acknowledge bits and read data are driven through a single pull-low enable that models the open-drain output.

Commands that change state (wiper or data-register writes and the register/wiper transfers) are handed to the back end as a one-cycle strobe, and only once the closing stop condition is seen. A dedicated step operation makes the slave translate every following clock pulse into an up or down strobe for the selected potentiometer, using the data line level as the direction, until a stop ends the stream. While the back end reports a nonvolatile write in progress, the slave refuses its own address, so a master can poll for completion.

Top module: `pot_cmd_slave`

## Requirements
- R1: A start (data falling while clock high) in any state restarts address reception; a stop (data rising while clock high) in any state returns the slave to idle, and an unfinished command is discarded.
- R2: The address byte is taken MSB first; the slave pulls data low in the ninth clock only if bits 7..4 equal 0101 and bits 3..0 equal `dev_pins_i` (bit 3 first); otherwise it stays silent and ignores the bus until the next start.
- R3: While `nv_busy_i` is high at the end of the address byte the address is not acknowledged; with it low the same address is acknowledged.
- R4: The instruction byte holds the opcode in bits 7..4, the register slot in bits 3..2 and the potentiometer in bits 1..0. Opcodes 1001, 1010, 1011, 1100, 1101, 1110, 0010 are acknowledged; 0001 and 1000 are acknowledged only with bits 1..0 equal 00; any other byte is not acknowledged and the slave goes idle.
- R5: For opcodes 1010 (wiper write) and 1100 (register write) a third byte is received and acknowledged, and on the stop `cmd_valid_o` pulses with the opcode, slot, pot and `cmd_data_o` equal to that byte.
- R6: Opcodes 1101, 1110, 0001 and 1000 take no data byte; on the stop after the instruction acknowledge `cmd_valid_o` pulses with the decoded fields.
- R7: `cmd_valid_o` is a single-cycle pulse raised only by a stop; a write stopped before its data byte is acknowledged issues nothing, and read opcodes issue nothing.
- R8: For opcodes 1001 and 1011 the slave captures `rd_data_i` at the end of the instruction acknowledge and sends it MSB first, changing the data line only while the clock is low, then releases the line for the master's acknowledge.
- R9: After opcode 0010 is acknowledged, each clock pulse produces one strobe at the clock's falling edge: `step_up_o` if data was high at the rising edge, `step_dn_o` if low. The pulse that carries the stop produces no strobe, and no strobe follows the stop.
- R10: During reset and in idle the data line is released (`sda_oe_o` low), and every acknowledge is released at the falling edge that ends its ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | High pulls the data line low |
| dev_pins_i | input | 4 | Device address strap pins, matched to address bits 3..0 |
| nv_busy_i | input | 1 | Back end is busy with a nonvolatile write |
| rd_data_i | input | 8 | Read value for the selected slot and pot |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the last accepted instruction |
| cmd_reg_o | output | 2 | Register slot of the last accepted instruction |
| cmd_pot_o | output | 2 | Potentiometer of the last accepted instruction |
| cmd_data_o | output | 8 | Last received data byte |
| step_up_o | output | 1 | One-cycle step toward the high end |
| step_dn_o | output | 1 | One-cycle step toward the low end |

## Verification
Every bus line change passes two synchronizer flops and one edge register, so the slave's reaction (an acknowledge, the next read bit, a released line) appears three system clocks after the clock edge that causes it, and strobes appear on that same edge. The bench holds each bus half-period for 20 system clocks and samples the data line in the middle of the high phase, well after that three-cycle lag has settled. Strobes are tallied by monitors on every clock and the tallies and captured fields are compared only after a stop plus a full half-period, so the one-cycle pulses cannot be missed or double-counted.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_REG   = 4'b1011;
  localparam logic [3:0] OP_WR_REG   = 4'b1100;
  localparam logic [3:0] OP_REG2WIP  = 4'b1101;
  localparam logic [3:0] OP_WIP2REG  = 4'b1110;
  localparam logic [3:0] OP_ALL_R2W  = 4'b0001;
  localparam logic [3:0] OP_ALL_W2R  = 4'b1000;
  localparam logic [3:0] OP_STEP     = 4'b0010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK,
    ST_STEP, ST_PEND, ST_HOLD
  } pcs_state_e;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] slot;
    logic [1:0] pot;
  } pcs_instr_t;

  function automatic logic op_reads(input logic [3:0] op);
    return (op == OP_RD_WIPER) || (op == OP_RD_REG);
  endfunction

  function automatic logic op_writes(input logic [3:0] op);
    return (op == OP_WR_WIPER) || (op == OP_WR_REG);
  endfunction

  function automatic logic op_global(input logic [3:0] op);
    return (op == OP_ALL_R2W) || (op == OP_ALL_W2R);
  endfunction

  function automatic logic op_accepts(input logic [3:0] op, input logic [1:0] pot);
    logic ok;
    ok = op_reads(op) || op_writes(op) || (op == OP_REG2WIP) ||
         (op == OP_WIP2REG) || (op == OP_STEP);
    if (op_global(op)) ok = (pot == 2'b00);
    return ok;
  endfunction

  function automatic logic addr_hit(input logic [7:0] rx, input logic [3:0] dtype,
                                    input logic [3:0] pins, input logic busy);
    return (rx[7:4] == dtype) && (rx[3:0] == pins) && !busy;
  endfunction

endpackage

// File: rtl/pcs_line_sync.sv
module pcs_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/pcs_cond_detect.sv
module pcs_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s_i;
      sda_p <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_p;
  assign scl_fall_o = ~scl_s_i & scl_p;
  assign start_o    = scl_s_i & scl_p & sda_p & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_p & ~sda_p & sda_s_i;
endmodule

// File: rtl/pcs_proto_fsm.sv
module pcs_proto_fsm
  import pcs_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise_i,
  input  logic        scl_fall_i,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        sda_lvl_i,
  input  logic [3:0]  dev_pins_i,
  input  logic        nv_busy_i,
  input  logic [7:0]  rd_data_i,
  output logic        sda_oe_o,
  output pcs_instr_t  instr_o,
  output logic [7:0]  data_o,
  output logic        cmd_valid_o,
  output logic        step_up_o,
  output logic        step_dn_o,
  output logic        addr_acking_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  pcs_state_e       state;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       rx, tx;
  logic             dir, armed;

  assign addr_acking_o = (state == ST_ADDR_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      rx          <= '0;
      tx          <= '0;
      dir         <= 1'b0;
      armed       <= 1'b0;
      sda_oe_o    <= 1'b0;
      instr_o     <= '0;
      data_o      <= '0;
      cmd_valid_o <= 1'b0;
      step_up_o   <= 1'b0;
      step_dn_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      step_up_o   <= 1'b0;
      step_dn_o   <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        if (state == ST_PEND) cmd_valid_o <= 1'b1;
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INSTR, ST_WDATA: begin
            if (scl_rise_i && bit_cnt != FULL) begin
              rx      <= {rx[6:0], sda_lvl_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit(rx, DEV_TYPE, dev_pins_i, nv_busy_i)) begin
                  state    <= ST_ADDR_ACK;
                  sda_oe_o <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_INSTR) begin
                if (op_accepts(rx[7:4], rx[1:0])) begin
                  instr_o  <= rx;
                  state    <= ST_INSTR_ACK;
                  sda_oe_o <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                data_o   <= rx;
                state    <= ST_WDATA_ACK;
                sda_oe_o <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_INSTR;
            end
          end
          ST_INSTR_ACK: begin
            if (scl_fall_i) begin
              bit_cnt <= '0;
              armed   <= 1'b0;
              if (op_reads(instr_o.op)) begin
                tx       <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                bit_cnt  <= CNT_W'(1);
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                if (op_writes(instr_o.op))      state <= ST_WDATA;
                else if (instr_o.op == OP_STEP) state <= ST_STEP;
                else                            state <= ST_PEND;
              end
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_PEND;
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (bit_cnt == FULL) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RDATA_ACK;
              end else begin
                sda_oe_o <= ~tx[6];
                tx       <= {tx[6:0], 1'b0};
                bit_cnt  <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_fall_i) state <= ST_HOLD;
          end
          ST_STEP: begin
            if (scl_rise_i) begin
              dir   <= sda_lvl_i;
              armed <= 1'b1;
            end else if (scl_fall_i && armed) begin
              step_up_o <= dir;
              step_dn_o <= ~dir;
              armed     <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pot_cmd_slave.sv
module pot_cmd_slave
  import pcs_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [3:0] dev_pins_i,
  input  logic       nv_busy_i,
  input  logic [7:0] rd_data_i,
  output logic       cmd_valid_o,
  output logic [3:0] cmd_op_o,
  output logic [1:0] cmd_reg_o,
  output logic [1:0] cmd_pot_o,
  output logic [7:0] cmd_data_o,
  output logic       step_up_o,
  output logic       step_dn_o
);
  logic [1:0] lines_s;
  logic       scl_lvl, sda_lvl;
  logic       scl_rise, scl_fall, start_evt, stop_evt;
  logic       addr_acking;
  pcs_instr_t instr;

  pcs_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(lines_s)
  );
  assign scl_lvl = lines_s[1];
  assign sda_lvl = lines_s[0];

  pcs_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s_i(scl_lvl), .sda_s_i(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  pcs_proto_fsm #(.DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .sda_lvl_i(sda_lvl),
    .dev_pins_i(dev_pins_i), .nv_busy_i(nv_busy_i), .rd_data_i(rd_data_i),
    .sda_oe_o(sda_oe_o), .instr_o(instr), .data_o(cmd_data_o),
    .cmd_valid_o(cmd_valid_o), .step_up_o(step_up_o), .step_dn_o(step_dn_o),
    .addr_acking_o(addr_acking)
  );

  assign cmd_op_o  = instr.op;
  assign cmd_reg_o = instr.slot;
  assign cmd_pot_o = instr.pot;
endmodule

// File: rtl/pcs_checks.sv
module pcs_checks (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_oe,
  input logic cmd_valid,
  input logic step_up,
  input logic step_dn,
  input logic addr_acking,
  input logic nv_busy
);
  // R8: the data line driver moves only while the clock is low (bus conditions excepted)
  p_oe_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_lvl));

  // R7: a command strobe follows a stop and lasts one cycle
  p_cmd_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(stop_evt));
  p_cmd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R9: step strobes are exclusive and come from a clock falling edge
  p_step_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
  p_step_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> $past(scl_fall));

  // R3: an address acknowledge never starts while the back end is busy
  p_no_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_acking) |-> !$past(nv_busy));

  // R10: acknowledge drive is released on a clock falling edge
  p_ack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_acking) && !$past(start_evt) && !$past(stop_evt) |-> $past(scl_fall));
endmodule

bind pot_cmd_slave pcs_checks u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_fall(scl_fall),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_oe(sda_oe_o),
  .cmd_valid(cmd_valid_o), .step_up(step_up_o), .step_dn(step_dn_o),
  .addr_acking(addr_acking), .nv_busy(nv_busy_i)
);

// File: tb/tb_pot_cmd_slave.sv
module tb_pot_cmd_slave;
  localparam int HP = 20;
  localparam logic [3:0] PINS = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic nv_busy = 1'b0;
  logic sda_oe, cmd_valid, step_up, step_dn;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [7:0] cmd_data, rd_data;
  wire sda_line = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0;
  int n_cmd = 0, n_up = 0, n_dn = 0, n_oe_glitch = 0;
  logic [3:0] last_op; logic [1:0] last_reg, last_pot; logic [7:0] last_data;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rd_data = {cmd_pot, cmd_reg, 4'b0110} ^ 8'h81;

  pot_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .dev_pins_i(PINS), .nv_busy_i(nv_busy), .rd_data_i(rd_data),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_reg_o(cmd_reg),
    .cmd_pot_o(cmd_pot), .cmd_data_o(cmd_data), .step_up_o(step_up), .step_dn_o(step_dn)
  );

  always @(posedge clk) begin
    if (cmd_valid) begin
      n_cmd++; last_op = cmd_op; last_reg = cmd_reg; last_pot = cmd_pot; last_data = cmd_data;
    end
    if (step_up) n_up++;
    if (step_dn) n_dn++;
  end

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe != oe_prev && scl_m) n_oe_glitch++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hp(); repeat (HP) @(negedge clk); endtask

  task automatic b_start();
    sda_m = 1; hp(); scl_m = 1; hp(); sda_m = 0; hp(); scl_m = 0; hp();
  endtask

  task automatic b_stop();
    sda_m = 0; hp(); scl_m = 1; hp(); sda_m = 1; hp(); hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1; hp(); scl_m = 0;
    end
    sda_m = 1; hp(); scl_m = 1;
    repeat (HP/2) @(negedge clk);
    ack = ~sda_line;
    repeat (HP/2) @(negedge clk);
    scl_m = 0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1; hp(); scl_m = 1;
      repeat (HP/2) @(negedge clk);
      b = {b[6:0], sda_line};
      repeat (HP/2) @(negedge clk);
      scl_m = 0;
    end
    sda_m = ~mack; hp(); scl_m = 1; hp(); scl_m = 0;
  endtask

  task automatic pulse(input bit up);
    sda_m = up; hp(); scl_m = 1; hp(); scl_m = 0;
  endtask

  task automatic t_reset();
    chk(sda_oe == 0, "R10", "oe in reset", sda_oe, 0);
    chk(cmd_valid == 0 && step_up == 0 && step_dn == 0, "R10", "strobes in reset", {cmd_valid, step_up, step_dn}, 0);
  endtask

  task automatic t_write_wiper();
    bit a1, a2, a3; int c0 = n_cmd;
    b_start();
    send_byte({4'b0101, PINS}, a1);
    send_byte(8'b1010_00_11, a2);
    send_byte(8'h5A, a3);
    chk(a1 && a2, "R2", "address/instr ack", {a1, a2}, 3);
    chk(a3, "R5", "data ack", a3, 1);
    hp();
    chk(n_cmd == c0, "R7", "no cmd before stop", n_cmd - c0, 0);
    chk(sda_oe == 0, "R10", "ack released", sda_oe, 0);
    b_stop();
    chk(n_cmd == c0 + 1, "R5", "cmd count", n_cmd - c0, 1);
    chk(last_op == 4'b1010 && last_pot == 2'b11 && last_data == 8'h5A, "R5", "cmd fields",
        {last_op, last_pot, last_data}, {4'b1010, 2'b11, 8'h5A});
  endtask

  task automatic t_bad_address();
    bit a, b; int c0 = n_cmd;
    b_start(); send_byte(8'b0110_1010, a); send_byte(8'b1101_00_00, b); b_stop();
    chk(!a && !b, "R2", "wrong type nack", {a, b}, 0);
    b_start(); send_byte({4'b0101, 4'b1011}, a); send_byte(8'b1101_00_00, b); b_stop();
    chk(!a && !b, "R2", "wrong pins nack", {a, b}, 0);
    chk(n_cmd == c0, "R2", "nothing issued", n_cmd - c0, 0);
  endtask

  task automatic t_busy_poll();
    bit a;
    nv_busy = 1;
    b_start(); send_byte({4'b0101, PINS}, a); b_stop();
    chk(!a, "R3", "nack while busy", a, 0);
    nv_busy = 0;
    b_start(); send_byte({4'b0101, PINS}, a); b_stop();
    chk(a, "R3", "ack after busy", a, 1);
  endtask

  task automatic t_instr_decode();
    bit a, b, c; int c0 = n_cmd;
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b0111_00_00, b);
    send_byte(8'h33, c); b_stop();
    chk(a && !b && !c, "R4", "unknown opcode nack", {a, b, c}, 4);
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b0001_00_01, b); b_stop();
    chk(!b, "R4", "global with pot nack", b, 0);
    chk(n_cmd == c0, "R4", "rejected not issued", n_cmd - c0, 0);
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b1000_10_00, b); b_stop();
    chk(b && n_cmd == c0 + 1 && last_op == 4'b1000 && last_reg == 2'b10, "R6", "global xfer",
        {b, last_op, last_reg}, {1'b1, 4'b1000, 2'b10});
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b1101_01_10, b); b_stop();
    chk(n_cmd == c0 + 2 && last_op == 4'b1101 && last_reg == 2'b01 && last_pot == 2'b10, "R6",
        "single xfer", {last_op, last_reg, last_pot}, {4'b1101, 2'b01, 2'b10});
  endtask

  task automatic t_read();
    bit a, b; logic [7:0] v; int c0 = n_cmd; int g0 = n_oe_glitch;
    logic [7:0] exp = {2'b01, 2'b10, 4'b0110} ^ 8'h81;
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b1011_10_01, b);
    recv_byte(v, 1'b0);
    hp();
    chk(sda_oe == 0, "R8", "released for master ack", sda_oe, 0);
    b_stop();
    chk(v == exp, "R8", "read byte", v, exp);
    chk(n_oe_glitch == g0, "R8", "oe change while scl high", n_oe_glitch - g0, 0);
    chk(n_cmd == c0, "R7", "read issues nothing", n_cmd - c0, 0);
  endtask

  task automatic t_step();
    bit a, b; int u0 = n_up, d0 = n_dn;
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b0010_00_10, b);
    pulse(1); pulse(1); pulse(0); pulse(1); pulse(0);
    hp();
    chk(n_up - u0 == 3 && n_dn - d0 == 2, "R9", "step counts", (n_up - u0) * 16 + (n_dn - d0), 8'h32);
    b_stop();
    pulse(1); pulse(0); hp();
    chk(n_up - u0 == 3 && n_dn - d0 == 2, "R9", "no steps from stop or after", (n_up - u0) * 16 + (n_dn - d0), 8'h32);
  endtask

  task automatic t_restart();
    bit a, b, c; int c0 = n_cmd;
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b1100_01_00, b);
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b1010_00_01, b);
    send_byte(8'hC3, c); b_stop();
    chk(n_cmd == c0 + 1 && last_op == 4'b1010 && last_data == 8'hC3, "R1", "restart takes new command",
        {last_op, last_data}, {4'b1010, 8'hC3});
    b_start(); send_byte({4'b0101, PINS}, a); send_byte(8'b1100_11_11, b); b_stop();
    chk(n_cmd == c0 + 1, "R7", "write stopped early not issued", n_cmd - c0, 1);
    chk(sda_oe == 0, "R1", "idle after stop", sda_oe, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (10) @(negedge clk);
    t_write_wiper();
    t_bad_address();
    t_busy_poll();
    t_instr_decode();
    t_read();
    t_step();
    t_restart();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule